// File: doc/BRIEF.md
# Pixel Serializer with Rate Prescale

This block turns a stream of 8-pixel bytes into a one-bit monochrome video signal for the visible part of each scan line. A timing generator drives a level strobe that is high for the whole active interval of a line. Inside that interval the block opens a display window of a fixed number of byte slots. At the start of each slot it parallel-loads one byte into a shift register. It then shifts the byte out one pixel at a time, with each pixel held for a fixed number of system clocks. Every clock of the active interval outside the window, and every clock while the strobe is low, is driven black.

Bytes arrive over a ready/valid handshake into a one-entry holding buffer. The buffer empties at every slot start, so the request for the following slot rises almost a full slot ahead of the time it is needed. When a slot starts with the buffer empty, that slot is shown black and a sticky starvation flag is raised. The flag stays high until an explicit clear. With the default parameters (4 clocks per pixel, 8 pixels per byte, 32 bytes per line, a 7-clock leading border), the window spans 1024 clocks. A 1039-clock active interval then leaves borders of 7 and 8 clocks.

Control is a four-state machine. The states are `ST_IDLE`, `ST_LEAD`, `ST_SHOW` and `ST_TAIL`, and the transitions are:
- start: `ST_IDLE`→`ST_LEAD` when the strobe is high.
- open: `ST_LEAD`→`ST_SHOW` when the leading border count is done.
- close: `ST_SHOW`→`ST_TAIL` at the end of the last slot.
- abort: any state→`ST_IDLE` when the strobe is low.

Top module: `pixel_serializer`

## Requirements
- R1: After reset, `video_out` is 0, `pix_ready` is 1 and `underrun` is 0.
- R2: After the first clock edge that samples `line_active` high, `video_out` stays black (0) for 7 clock periods.
- R3: Each pixel is held on `video_out` for exactly 4 clock periods, and bit 7 of a byte is shown first, down to bit 0 last.
- R4: The display window holds 32 consecutive slots of 32 clocks, one byte per slot, and so spans 1024 clocks. Its first pixel starts 7 periods after the rising-edge sample.
- R5: After the window closes, `video_out` stays black until `line_active` falls. With a 1039-clock interval, this gives an 8-clock trailing border.
- R6: In the period after any edge that samples `line_active` low, `video_out` is black. A fall in the middle of a line abandons that line, and the next rise restarts from the leading border.
- R7: The input buffer holds one byte. `pix_ready` is high exactly when the buffer is empty, a byte is taken on an edge where `pix_valid` and `pix_ready` are both high, and `pix_ready` is low in the following period.
- R8: In the period after every slot start, `pix_ready` is high, so the request for the next slot is raised 31 clocks before it is needed.
- R9: If the buffer is empty at a slot start, that whole slot is black and `underrun` goes high in the following period.
- R10: `underrun` stays high until an edge samples `underrun_clr` high with no new starvation on that edge; it is then 0 in the following period.
- R11: Bytes are shown in the order they were accepted. A byte left in the buffer when a line is abandoned is shown in the first slot of the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_active | input | 1 | High for the active interval of a line |
| pix_data | input | 8 | Eight pixels, bit 7 shown first |
| pix_valid | input | 1 | `pix_data` holds a byte |
| pix_ready | output | 1 | Buffer empty; a byte is accepted on this edge |
| underrun_clr | input | 1 | Clears the starvation flag |
| video_out | output | 1 | Serial pixel output, 1 = lit |
| underrun | output | 1 | Sticky flag: a slot started with no byte |

## Verification
The bench builds the block with its default parameters: 4 clocks per pixel, 8 pixels per byte, 32 slots and a 7-clock leading border. Each line it drives has a 1039-clock strobe, so the exact 7/1024/8 split is checked clock by clock. These values put the 7-to-8 border boundaries, the final slot and the slot-start request timing within reach in one short run. A prefetched byte before the line, a five-byte starved line, and a line dropped in its first slot then restarted also become reachable.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHOW,
        ST_TAIL
    } pxs_state_e;

endpackage

// File: rtl/pxs_timing.sv
module pxs_timing
    import pxs_pkg::*;
#(
    parameter int CLKS_PER_PIX   = 4,
    parameter int PIX_PER_BYTE   = 8,
    parameter int BYTES_PER_LINE = 32,
    parameter int LEAD_CLKS      = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic load,
    output logic shift,
    output logic line_end,
    output logic show
);

    localparam int LW = $clog2(LEAD_CLKS + 1);
    localparam int PW = $clog2(CLKS_PER_PIX + 1);
    localparam int BW = $clog2(PIX_PER_BYTE + 1);
    localparam int SW = $clog2(BYTES_PER_LINE + 1);

    pxs_state_e state, state_nx;

    logic [LW-1:0] lead_cnt;
    logic [PW-1:0] pix_cnt;
    logic [BW-1:0] bit_cnt;
    logic [SW-1:0] slot_cnt;

    logic lead_done, pix_end, byte_end, last_slot;

    assign lead_done = (state == ST_LEAD) && (lead_cnt == LW'(LEAD_CLKS - 1));
    assign pix_end   = (pix_cnt == PW'(CLKS_PER_PIX - 1));
    assign byte_end  = pix_end && (bit_cnt == BW'(PIX_PER_BYTE - 1));
    assign last_slot = (slot_cnt == SW'(BYTES_PER_LINE - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: start, open, close, abort
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (active) state_nx = ST_LEAD;
            ST_LEAD: begin
                if (!active)        state_nx = ST_IDLE;
                else if (lead_done) state_nx = ST_SHOW;
            end
            ST_SHOW: begin
                if (!active)                    state_nx = ST_IDLE;
                else if (byte_end && last_slot) state_nx = ST_TAIL;
            end
            ST_TAIL: if (!active) state_nx = ST_IDLE;
        endcase
    end

    // strobes towards the datapath
    always_comb begin
        show     = (state == ST_SHOW);
        load     = active && (lead_done || (show && byte_end && !last_slot));
        shift    = active && show && pix_end && !byte_end;
        line_end = active && show && byte_end && last_slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_cnt <= '0;
            pix_cnt  <= '0;
            bit_cnt  <= '0;
            slot_cnt <= '0;
        end else begin
            if (state == ST_LEAD) lead_cnt <= lead_cnt + LW'(1);
            else                  lead_cnt <= '0;

            if (load) begin
                pix_cnt  <= '0;
                bit_cnt  <= '0;
                slot_cnt <= lead_done ? '0 : slot_cnt + SW'(1);
            end else if (show) begin
                if (pix_end) begin
                    pix_cnt <= '0;
                    bit_cnt <= bit_cnt + BW'(1);
                end else begin
                    pix_cnt <= pix_cnt + PW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pxs_fetch.sv
module pxs_fetch #(
    parameter int PIX_PER_BYTE = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PIX_PER_BYTE-1:0] in_data,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    take,
    output logic [PIX_PER_BYTE-1:0] held_data,
    output logic                    held_full
);

    logic accept;

    assign in_ready = !held_full;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_full <= 1'b0;
            held_data <= '0;
        end else begin
            if (take)   held_full <= 1'b0;
            if (accept) begin
                held_full <= 1'b1;
                held_data <= in_data;
            end
        end
    end

endmodule

// File: rtl/pxs_shifter.sv
module pxs_shifter #(
    parameter int PIX_PER_BYTE = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    shift,
    input  logic                    show,
    input  logic                    fill_ok,
    input  logic [PIX_PER_BYTE-1:0] fill_data,
    output logic                    starve,
    output logic                    video
);

    logic [PIX_PER_BYTE-1:0] shreg;
    logic                    slot_ok;

    assign starve = load && !fill_ok;
    assign video  = show && slot_ok && shreg[PIX_PER_BYTE-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            slot_ok <= 1'b0;
        end else if (load) begin
            slot_ok <= fill_ok;
            shreg   <= fill_ok ? fill_data : '0;
        end else if (shift) begin
            shreg   <= {shreg[PIX_PER_BYTE-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer #(
    parameter int CLKS_PER_PIX   = 4,
    parameter int PIX_PER_BYTE   = 8,
    parameter int BYTES_PER_LINE = 32,
    parameter int LEAD_CLKS      = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_active,
    input  logic [PIX_PER_BYTE-1:0] pix_data,
    input  logic                    pix_valid,
    output logic                    pix_ready,
    input  logic                    underrun_clr,
    output logic                    video_out,
    output logic                    underrun
);

    logic t_load, t_shift, t_line_end, t_show;
    logic [PIX_PER_BYTE-1:0] held_data;
    logic held_full, starve;

    pxs_timing #(
        .CLKS_PER_PIX  (CLKS_PER_PIX),
        .PIX_PER_BYTE  (PIX_PER_BYTE),
        .BYTES_PER_LINE(BYTES_PER_LINE),
        .LEAD_CLKS     (LEAD_CLKS)
    ) u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (line_active),
        .load    (t_load),
        .shift   (t_shift),
        .line_end(t_line_end),
        .show    (t_show)
    );

    pxs_fetch #(.PIX_PER_BYTE(PIX_PER_BYTE)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (pix_data),
        .in_valid (pix_valid),
        .in_ready (pix_ready),
        .take     (t_load),
        .held_data(held_data),
        .held_full(held_full)
    );

    pxs_shifter #(.PIX_PER_BYTE(PIX_PER_BYTE)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .shift    (t_shift),
        .show     (t_show),
        .fill_ok  (held_full),
        .fill_data(held_data),
        .starve   (starve),
        .video    (video_out)
    );

    // sticky starvation flag, a new event wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            underrun <= 1'b0;
        else if (starve)       underrun <= 1'b1;
        else if (underrun_clr) underrun <= 1'b0;
    end

endmodule

// File: rtl/pixel_serializer_chk.sv
module pixel_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic line_active,
    input logic pix_valid,
    input logic pix_ready,
    input logic underrun_clr,
    input logic video_out,
    input logic underrun,
    input logic load,
    input logic shift,
    input logic line_end,
    input logic buf_full
);

    AST_BLACK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !line_active |=> !video_out); // R6

    AST_LEAD_BORDER_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_active) |=> !video_out); // R2

    AST_PIXEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (line_active && !load && !shift && !line_end) |=> $stable(video_out)); // R3

    AST_ONE_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |=> !pix_ready); // R7

    AST_REQ_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pix_ready); // R8

    AST_STARVE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !buf_full) |=> underrun); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !underrun_clr) |=> underrun); // R10

endmodule

bind pixel_serializer pixel_serializer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_active (line_active),
    .pix_valid   (pix_valid),
    .pix_ready   (pix_ready),
    .underrun_clr(underrun_clr),
    .video_out   (video_out),
    .underrun    (underrun),
    .load        (t_load),
    .shift       (t_shift),
    .line_end    (t_line_end),
    .buf_full    (held_full)
);

// File: tb/pixel_serializer_test.sv
`timescale 1ns/1ps
module pixel_serializer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_active = 1'b0;
    logic [7:0] pix_data;
    logic       pix_valid;
    logic       pix_ready;
    logic       underrun_clr = 1'b0;
    logic       video_out;
    logic       underrun;

    int tests = 0;
    int fails = 0;

    logic [7:0] bytes [0:39];
    int  acc_cnt = 0;
    int  feed_base = 0;
    int  feed_lim = 0;
    logic feed_en = 1'b0;

    always #4 clk = ~clk;

    pixel_serializer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_active (line_active),
        .pix_data    (pix_data),
        .pix_valid   (pix_valid),
        .pix_ready   (pix_ready),
        .underrun_clr(underrun_clr),
        .video_out   (video_out),
        .underrun    (underrun)
    );

    assign pix_valid = feed_en && ((acc_cnt - feed_base) < feed_lim);
    assign pix_data  = ((acc_cnt - feed_base) < 40) ? bytes[acc_cnt - feed_base] : 8'h00;

    always @(posedge clk) begin
        if (pix_valid && pix_ready) acc_cnt <= acc_cnt + 1;
    end

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic logic exp_vid(input int n, input int base, input int avail);
        int p, s;
        if (n < 7 || n > 1030) return 1'b0;
        p = n - 7;
        s = p / 32;
        if (s >= avail) return 1'b0;
        return bytes[base + s][7 - (p % 32) / 4];
    endfunction

    // one full line of 1039 active clocks, checked every period
    task automatic run_line(input int base, input int avail, input string tag);
        @(negedge clk);
        line_active = 1'b1;
        for (int n = 0; n <= 1040; n++) begin
            @(negedge clk);
            if (n < 7)
                chk(video_out, 1'b0, "R2", $sformatf("%s lead n=%0d", tag, n));
            else if (n <= 1030)
                chk(video_out, exp_vid(n, base, avail), "R3/R4",
                    $sformatf("%s pixel n=%0d", tag, n));
            else
                chk(video_out, 1'b0, "R5", $sformatf("%s tail n=%0d", tag, n));
            if (n >= 7 && n <= 1030 && ((n - 7) % 32) == 0)
                chk(pix_ready, 1'b1, "R8", $sformatf("%s request n=%0d", tag, n));
            if (avail < 32 && n == 6 + 32 * avail)
                chk(underrun, 1'b0, "R9", $sformatf("%s flag before n=%0d", tag, n));
            if (avail < 32 && n == 7 + 32 * avail)
                chk(underrun, 1'b1, "R9", $sformatf("%s flag at n=%0d", tag, n));
            if (n == 1038) line_active = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(video_out, 1'b0, "R1", "video after reset");
        chk(pix_ready, 1'b1, "R1", "ready after reset");
        chk(underrun, 1'b0, "R1", "flag after reset");
    endtask

    task automatic t_full_line();
        feed_base = acc_cnt;
        feed_lim  = 32;
        feed_en   = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(pix_ready, 1'b0, "R7", "ready low once prefetched");
        chk(video_out, 1'b0, "R6", "black before line");
        run_line(0, 32, "full");
        chk(underrun, 1'b0, "R9", "no starvation on fed line");
    endtask

    task automatic t_underrun();
        feed_base = acc_cnt;
        feed_lim  = 5;
        repeat (2) @(negedge clk);
        run_line(0, 5, "starved");
    endtask

    task automatic t_clear();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(underrun, 1'b1, "R10", $sformatf("flag held %0d", i));
        end
        underrun_clr = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
        chk(underrun, 1'b0, "R10", "flag cleared");
        repeat (3) @(negedge clk);
        chk(underrun, 1'b0, "R10", "flag stays clear");
    endtask

    task automatic t_abort();
        feed_base = acc_cnt;
        feed_lim  = 2;
        repeat (3) @(negedge clk);
        line_active = 1'b1;
        for (int n = 0; n <= 30; n++) begin
            @(negedge clk);
            if (n >= 7 && n <= 10)
                chk(video_out, bytes[0][7], "R3", $sformatf("abort line n=%0d", n));
            else
                chk(video_out, 1'b0, "R6", $sformatf("abort black n=%0d", n));
            if (n == 10) line_active = 1'b0;
        end
        chk(pix_ready, 1'b0, "R11", "leftover byte still buffered");
        // restarted line shows the leftover byte first, then starves
        run_line(1, 1, "R11 restart");
    endtask

    initial begin
        for (int k = 0; k < 40; k++) bytes[k] = 8'(k * 59 + 150);
        t_reset();
        t_full_line();
        t_underrun();
        t_clear();
        t_abort();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule